// File: doc/BRIEF.md
# SDRAM Start-up and Refresh Keeper

This block owns the SDRAM command lines from power-on until the memory is usable. It then keeps the memory refreshed for as long as the chip runs. After reset it holds the command bus at NOP with clock enable high while the clock settles. It then closes every bank with one precharge, issues a configurable number of auto-refresh commands and writes the mode value.

Once that sequence ends it raises `ready_o`, which hands the bus to the main sequencer. A free-running interval counter marks a refresh as due every `T_REFI` cycles. Self-refresh can also be requested from outside. For either job the block raises `upkeep_req_o` and waits until the main sequencer reports with `idle_in` that all banks are closed. It then issues the command and keeps the bus quiet for the recovery time. All waits are parameters counted in clock cycles, and the defaults suit a 133 MHz clock.

The state machine has these states: `ST_PWRUP` (stable-clock wait), `ST_PRE_ALL` then `ST_RP_WAIT` (precharge and its recovery), `ST_INIT_REF` then `ST_INIT_RFC` (start-up refresh loop, which returns to `ST_INIT_REF` until the count is reached), `ST_MODE_SET` then `ST_RSC_WAIT`, and `ST_READY`. From `ST_READY` a due refresh or a self-refresh request moves the machine to `ST_DRAIN`. `ST_DRAIN` goes to `ST_AUTO_REF` then `ST_AUTO_RFC` when idle and a refresh is due. It goes to `ST_SELF_IN` then `ST_SELF_HOLD` when idle with only self-refresh requested. It goes back to `ST_READY` if the self-refresh request is withdrawn. `ST_SELF_HOLD` leaves through `ST_SELF_OUT` to `ST_READY`.

Top module: `dram_upkeep`

## Requirements
- R1: Commands on `cmd_o` are coded as {cs_n, ras_n, cas_n, we_n}: NOP 4'b0111, precharge 4'b0010, auto-refresh 4'b0001, mode set 4'b0000. From reset release, for `T_POWERUP` cycles, the block drives NOP with `cke_o` high and both `ready_o` and `upkeep_req_o` low. It issues precharge in cycle `T_POWERUP` with `addr_o` bit 10 set (all banks).
- R2: The first start-up refresh follows the precharge after exactly `T_RP` cycles. `N_INIT_REF` refreshes are issued, consecutive ones `T_RFC` cycles apart, with NOP between them and `ready_o` low.
- R3: Mode set follows the last start-up refresh by `T_RFC` cycles with `addr_o` equal to `MODE_VAL`. `ready_o` first rises `T_RSC` cycles after the mode set.
- R4: Counting from the first cycle of `ready_o`, a refresh becomes due every `T_REFI` cycles. With `idle_in` held high, each auto-refresh is issued two cycles after it becomes due, so consecutive refreshes are exactly `T_REFI` cycles apart.
- R5: While a refresh or self-refresh waits, `upkeep_req_o` and `ready_o` are both high, and no refresh is issued until `idle_in` is sampled high. The refresh command appears in the cycle after that sample.
- R6: After any refresh command, `cmd_o` stays NOP and `ready_o` stays low for `T_RFC-1` cycles.
- R7: Self-refresh entry is a refresh command issued in the same cycle that `cke_o` falls. `cke_o` then stays low, with `ready_o` low, for as long as `self_req` stays high.
- R8: When `self_req` falls, `cke_o` rises in the next cycle. `ready_o` returns `T_RFC` cycles after that rise, with only NOP in between. The refresh interval restarts from the return of `ready_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| idle_in | input | 1 | Main sequencer reports all banks closed |
| self_req | input | 1 | Level request to enter and stay in self-refresh |
| cmd_o | output | 4 | Command {cs_n, ras_n, cas_n, we_n} |
| cke_o | output | 1 | Clock enable to the memory |
| addr_o | output | ADDR_W | Address bus (mode value, all-bank flag) |
| ready_o | output | 1 | Main sequencer may drive commands |
| upkeep_req_o | output | 1 | Asks the main sequencer to close all banks |

## Verification
The assertions assume that the main sequencer raises `idle_in` only after all banks are closed. They also assume it holds `self_req` steady from the moment the request appears until the block has entered self-refresh. The quiet-window property further assumes that the block, and not the sequencer, drives the bus while `ready_o` is low. The stimulus keeps to these assumptions. `idle_in` and `self_req` change only at chosen cycles away from the clock edge. `self_req` rises only while the block is ready and falls only while it is held in self-refresh. `idle_in` is dropped for a stretch that covers a due refresh, so the drain wait is actually exercised.

// File: rtl/dram_upkeep_pkg.sv
package dram_upkeep_pkg;

    typedef enum logic [3:0] {
        CMD_MODE  = 4'b0000,
        CMD_REF   = 4'b0001,
        CMD_PRE   = 4'b0010,
        CMD_NOP   = 4'b0111
    } cmd_e;

    typedef enum logic [3:0] {
        ST_PWRUP,
        ST_PRE_ALL,
        ST_RP_WAIT,
        ST_INIT_REF,
        ST_INIT_RFC,
        ST_MODE_SET,
        ST_RSC_WAIT,
        ST_READY,
        ST_DRAIN,
        ST_AUTO_REF,
        ST_AUTO_RFC,
        ST_SELF_IN,
        ST_SELF_HOLD,
        ST_SELF_OUT
    } state_e;

    localparam int ALL_BANK_BIT = 10;

endpackage

// File: rtl/dram_upkeep_delay.sv
module dram_upkeep_delay #(
    parameter int W       = 8,
    parameter int RST_VAL = 0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         zero
);
    logic [W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (!rst_n)            cnt <= W'(RST_VAL);
        else if (load)         cnt <= load_val;
        else if (cnt != '0)    cnt <= cnt - 1'b1;
    end

    assign zero = (cnt == '0);
endmodule

// File: rtl/dram_upkeep_interval.sv
module dram_upkeep_interval #(
    parameter int T_REFI = 1040
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic restart,
    input  logic ack,
    output logic pending
);
    localparam int CW = (T_REFI > 2) ? $clog2(T_REFI) : 1;
    localparam logic [CW-1:0] RELOAD = CW'(T_REFI - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt     <= RELOAD;
            pending <= 1'b0;
        end else if (!run || restart) begin
            cnt     <= RELOAD;
            pending <= 1'b0;
        end else if (cnt == '0) begin
            cnt     <= RELOAD;
            pending <= 1'b1;
        end else begin
            cnt <= cnt - 1'b1;
            if (ack) pending <= 1'b0;
        end
    end
endmodule

// File: rtl/dram_upkeep.sv
module dram_upkeep
    import dram_upkeep_pkg::*;
#(
    parameter int ADDR_W     = 13,
    parameter int T_POWERUP  = 26700,
    parameter int T_RP       = 3,
    parameter int T_RFC      = 10,
    parameter int T_RSC      = 2,
    parameter int N_INIT_REF = 8,
    parameter int T_REFI     = 1040,
    parameter logic [ADDR_W-1:0] MODE_VAL = ADDR_W'(12'h032)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              idle_in,
    input  logic              self_req,
    output logic [3:0]        cmd_o,
    output logic              cke_o,
    output logic [ADDR_W-1:0] addr_o,
    output logic              ready_o,
    output logic              upkeep_req_o
);
    localparam int TMAX_A = (T_POWERUP > T_RFC) ? T_POWERUP : T_RFC;
    localparam int TMAX_B = (T_RP > T_RSC) ? T_RP : T_RSC;
    localparam int TMAX   = (TMAX_A > TMAX_B) ? TMAX_A : TMAX_B;
    localparam int TW     = $clog2(TMAX + 1);
    localparam int RW     = $clog2(N_INIT_REF + 1);

    state_e          state, state_nx;
    logic            t_load, t_zero;
    logic [TW-1:0]   t_val;
    logic [RW-1:0]   ref_cnt;
    logic            init_done;
    logic            due;

    dram_upkeep_delay #(.W(TW), .RST_VAL(T_POWERUP - 1)) i_delay (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (t_load),
        .load_val (t_val),
        .zero     (t_zero)
    );

    dram_upkeep_interval #(.T_REFI(T_REFI)) i_interval (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (init_done),
        .restart (state inside {ST_SELF_IN, ST_SELF_HOLD, ST_SELF_OUT}),
        .ack     (state == ST_AUTO_REF),
        .pending (due)
    );

    // state register and its bookkeeping counters
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_PWRUP;
            ref_cnt   <= '0;
            init_done <= 1'b0;
        end else begin
            state <= state_nx;
            if (state == ST_INIT_REF) ref_cnt <= ref_cnt + 1'b1;
            if (state == ST_RSC_WAIT && t_zero) init_done <= 1'b1;
        end
    end

    // next state and wait loading
    always_comb begin
        state_nx = state;
        t_load   = 1'b0;
        t_val    = '0;
        unique case (state)
            ST_PWRUP:     if (t_zero) state_nx = ST_PRE_ALL;
            ST_PRE_ALL: begin
                t_load = 1'b1; t_val = TW'(T_RP - 2); state_nx = ST_RP_WAIT;
            end
            ST_RP_WAIT:   if (t_zero) state_nx = ST_INIT_REF;
            ST_INIT_REF: begin
                t_load = 1'b1; t_val = TW'(T_RFC - 2); state_nx = ST_INIT_RFC;
            end
            ST_INIT_RFC:
                if (t_zero) state_nx = (ref_cnt == RW'(N_INIT_REF)) ? ST_MODE_SET : ST_INIT_REF;
            ST_MODE_SET: begin
                t_load = 1'b1; t_val = TW'(T_RSC - 2); state_nx = ST_RSC_WAIT;
            end
            ST_RSC_WAIT:  if (t_zero) state_nx = ST_READY;
            ST_READY:     if (due || self_req) state_nx = ST_DRAIN;
            ST_DRAIN: begin
                if (idle_in && due)           state_nx = ST_AUTO_REF;
                else if (idle_in && self_req) state_nx = ST_SELF_IN;
                else if (!due && !self_req)   state_nx = ST_READY;
            end
            ST_AUTO_REF: begin
                t_load = 1'b1; t_val = TW'(T_RFC - 2); state_nx = ST_AUTO_RFC;
            end
            ST_AUTO_RFC:  if (t_zero) state_nx = ST_READY;
            ST_SELF_IN:   state_nx = ST_SELF_HOLD;
            ST_SELF_HOLD: if (!self_req) begin
                t_load = 1'b1; t_val = TW'(T_RFC - 1); state_nx = ST_SELF_OUT;
            end
            ST_SELF_OUT:  if (t_zero) state_nx = ST_READY;
            default:      state_nx = ST_PWRUP;
        endcase
    end

    // outputs decoded from the state
    always_comb begin
        cmd_o        = CMD_NOP;
        cke_o        = 1'b1;
        addr_o       = '0;
        ready_o      = 1'b0;
        upkeep_req_o = 1'b0;
        unique case (state)
            ST_PRE_ALL: begin
                cmd_o = CMD_PRE;
                addr_o[ALL_BANK_BIT] = 1'b1;
            end
            ST_INIT_REF, ST_AUTO_REF: cmd_o = CMD_REF;
            ST_MODE_SET: begin
                cmd_o  = CMD_MODE;
                addr_o = MODE_VAL;
            end
            ST_READY: ready_o = 1'b1;
            ST_DRAIN: begin
                ready_o      = 1'b1;
                upkeep_req_o = 1'b1;
            end
            ST_SELF_IN: begin
                cmd_o = CMD_REF;
                cke_o = 1'b0;
            end
            ST_SELF_HOLD: cke_o = 1'b0;
            default: ;
        endcase
    end
endmodule

// File: rtl/dram_upkeep_chk.sv
module dram_upkeep_chk
    import dram_upkeep_pkg::*;
#(
    parameter int ADDR_W = 13,
    parameter int T_RFC  = 10
) (
    input logic              clk,
    input logic              rst_n,
    input logic              idle_in,
    input logic              self_req,
    input logic [3:0]        cmd_o,
    input logic              cke_o,
    input logic [ADDR_W-1:0] addr_o,
    input logic              ready_o,
    input logic              upkeep_req_o
);
    localparam int QW = $clog2(T_RFC + 1) + 1;

    logic [QW-1:0] quiet;
    logic          cke_q;

    // cycles since the last refresh command or clock-enable rise, saturating
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            quiet <= QW'(T_RFC);
            cke_q <= 1'b1;
        end else begin
            cke_q <= cke_o;
            if (cmd_o == CMD_REF || (cke_o && !cke_q)) quiet <= QW'(1);
            else if (quiet < QW'(T_RFC))              quiet <= quiet + 1'b1;
        end
    end

    AST_PRE_ALL_BANKS: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_o == CMD_PRE |-> addr_o[ALL_BANK_BIT]);                            // R1

    AST_REF_AFTER_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_o == CMD_REF && $past(ready_o)) |-> $past(idle_in));              // R5

    AST_QUIET_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_o != CMD_NOP) |-> (quiet >= QW'(T_RFC)));                         // R6

    AST_CKE_FALL_IS_REF: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cke_o) |-> (cmd_o == CMD_REF));                                  // R7

    AST_READY_NEEDS_CKE: assert property (@(posedge clk) disable iff (!rst_n)
        ready_o |-> cke_o);                                                    // R8

    AST_DRAIN_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (upkeep_req_o && !idle_in && self_req) |=> upkeep_req_o);              // R5
endmodule

bind dram_upkeep dram_upkeep_chk #(.ADDR_W(ADDR_W), .T_RFC(T_RFC)) i_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .idle_in      (idle_in),
    .self_req     (self_req),
    .cmd_o        (cmd_o),
    .cke_o        (cke_o),
    .addr_o       (addr_o),
    .ready_o      (ready_o),
    .upkeep_req_o (upkeep_req_o)
);

// File: tb/test_dram_upkeep.sv
module test_dram_upkeep;
    localparam int AW   = 13;
    localparam int TP   = 20;
    localparam int TRP  = 3;
    localparam int TRFC = 10;
    localparam int TRSC = 2;
    localparam int NREF = 8;
    localparam int TREF = 60;
    localparam logic [AW-1:0] MODEV = 13'h032;

    localparam logic [3:0] NOP = 4'b0111, PRE = 4'b0010, REF = 4'b0001, MRS = 4'b0000;

    localparam int C_PRE   = TP;
    localparam int C_REF0  = C_PRE + TRP;
    localparam int C_MRS   = C_REF0 + NREF * TRFC;
    localparam int C_RDY   = C_MRS + TRSC;
    localparam int C_A1    = C_RDY + TREF + 2;
    localparam int C_A2    = C_A1 + TREF;
    localparam int C_IDLE0 = C_A2 + 13;
    localparam int C_IDLE1 = C_A2 + 73;
    localparam int C_A3    = C_IDLE1 + 1;
    localparam int C_A4    = C_RDY + 4 * TREF + 2;
    localparam int C_SREQ  = C_A4 + 13;
    localparam int C_SIN   = C_SREQ + 2;
    localparam int C_SOFF  = C_SIN + 88;
    localparam int C_SOUT  = C_SOFF + 1;
    localparam int C_RDY2  = C_SOUT + TRFC;
    localparam int C_A5    = C_RDY2 + TREF + 2;
    localparam int C_END   = C_A5 + 20;

    logic clk = 1'b0, rst_n = 1'b0, idle_in = 1'b1, self_req = 1'b0;
    logic [3:0] cmd_o;
    logic cke_o, ready_o, upkeep_req_o;
    logic [AW-1:0] addr_o;

    int cyc = 0, checks = 0, errors = 0;
    bit done = 1'b0;

    typedef struct {
        int cyc;
        logic [3:0] cmd;
        logic cke;
        logic [AW-1:0] addr;
    } ev_t;
    ev_t   exp_q[$];
    string tag_q[$];

    dram_upkeep #(.ADDR_W(AW), .T_POWERUP(TP), .T_RP(TRP), .T_RFC(TRFC),
                  .T_RSC(TRSC), .N_INIT_REF(NREF), .T_REFI(TREF), .MODE_VAL(MODEV))
    i_dram_upkeep (
        .clk(clk), .rst_n(rst_n), .idle_in(idle_in), .self_req(self_req),
        .cmd_o(cmd_o), .cke_o(cke_o), .addr_o(addr_o),
        .ready_o(ready_o), .upkeep_req_o(upkeep_req_o)
    );

    always #5 clk = ~clk;
    always @(posedge clk) if (rst_n) cyc <= cyc + 1;

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s at cycle %0d: actual %0h expected %0h", req, what, cyc, act, exp);
        end
    endtask

    task automatic push_ev(input int c, input logic [3:0] cm, input logic ck,
                           input logic [AW-1:0] ad, input string req);
        ev_t e;
        e.cyc = c; e.cmd = cm; e.cke = ck; e.addr = ad;
        exp_q.push_back(e);
        tag_q.push_back(req);
    endtask

    task automatic wait_to(input int k);
        while (cyc < k) @(negedge clk);
    endtask

    // monitor: every command or clock-enable change is an event
    initial begin
        logic cke_prev;
        cke_prev = 1'b1;
        forever begin
            @(negedge clk);
            if (rst_n && (cmd_o != NOP || cke_o != cke_prev)) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "R4", "unexpected command", int'(cmd_o), int'(NOP));
                end else begin
                    ev_t e;
                    string t;
                    e = exp_q.pop_front();
                    t = tag_q.pop_front();
                    check(cyc == e.cyc, t, "event cycle", cyc, e.cyc);
                    check(cmd_o == e.cmd, t, "command", int'(cmd_o), int'(e.cmd));
                    check(cke_o == e.cke, t, "clock enable", int'(cke_o), int'(e.cke));
                    check(addr_o == e.addr, t, "address", int'(addr_o), int'(e.addr));
                end
            end
            cke_prev = cke_o;
        end
    end

    // driver and point checks
    initial begin
        push_ev(C_PRE, PRE, 1'b1, 13'h400, "R1");
        for (int i = 0; i < NREF; i++)
            push_ev(C_REF0 + i * TRFC, REF, 1'b1, '0, "R2");
        push_ev(C_MRS, MRS, 1'b1, MODEV, "R3");
        push_ev(C_A1, REF, 1'b1, '0, "R4");
        push_ev(C_A2, REF, 1'b1, '0, "R4");
        push_ev(C_A3, REF, 1'b1, '0, "R5");
        push_ev(C_A4, REF, 1'b1, '0, "R4");
        push_ev(C_SIN, REF, 1'b0, '0, "R7");
        push_ev(C_SOUT, NOP, 1'b1, '0, "R8");
        push_ev(C_A5, REF, 1'b1, '0, "R8");

        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        wait_to(5);
        check(cmd_o == NOP, "R1", "powerup command", int'(cmd_o), int'(NOP));
        check(cke_o == 1'b1, "R1", "powerup cke", int'(cke_o), 1);
        check(ready_o == 1'b0, "R1", "powerup ready", int'(ready_o), 0);
        check(upkeep_req_o == 1'b0, "R1", "powerup request", int'(upkeep_req_o), 0);

        wait_to(C_REF0 + 5);
        check(ready_o == 1'b0, "R2", "ready during init refresh", int'(ready_o), 0);
        wait_to(C_RDY - 1);
        check(ready_o == 1'b0, "R3", "ready before tRSC", int'(ready_o), 0);
        wait_to(C_RDY);
        check(ready_o == 1'b1, "R3", "ready after tRSC", int'(ready_o), 1);

        wait_to(C_A1 + TRFC - 1);
        check(ready_o == 1'b0, "R6", "ready in refresh recovery", int'(ready_o), 0);
        wait_to(C_A1 + TRFC);
        check(ready_o == 1'b1, "R6", "ready after recovery", int'(ready_o), 1);

        wait_to(C_IDLE0);
        idle_in = 1'b0;
        wait_to(C_IDLE1 - 5);
        check(upkeep_req_o == 1'b1, "R5", "request while busy", int'(upkeep_req_o), 1);
        check(ready_o == 1'b1, "R5", "ready while draining", int'(ready_o), 1);
        wait_to(C_IDLE1);
        idle_in = 1'b1;
        wait_to(C_IDLE1 + 5);
        check(upkeep_req_o == 1'b0, "R5", "request released", int'(upkeep_req_o), 0);

        wait_to(C_SREQ);
        self_req = 1'b1;
        wait_to(C_SIN + 40);
        check(cke_o == 1'b0, "R7", "cke held low", int'(cke_o), 0);
        check(ready_o == 1'b0, "R7", "ready in self-refresh", int'(ready_o), 0);
        wait_to(C_SOFF);
        self_req = 1'b0;
        wait_to(C_RDY2 - 1);
        check(ready_o == 1'b0, "R8", "ready during exit wait", int'(ready_o), 0);
        wait_to(C_RDY2);
        check(ready_o == 1'b1, "R8", "ready after exit wait", int'(ready_o), 1);

        wait_to(C_END);
        check(exp_q.size() == 0, "R4", "missing events", exp_q.size(), 0);
        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL R4 watchdog expired at cycle %0d: actual hung expected %0d", cyc, C_END);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule